// File: doc/BRIEF.md
# Transfer-Request List Walker

This block steps through a packed descriptor that holds a list of transfer-request records in memory. It is given the descriptor's base address, the first two header words and a start pulse. It checks the header, then presents one record at a time over a valid/ready handshake. Each record comes with its own address, the address of its 4-byte response slot and its index in the list.

Once the first pass over the list is finished, the walker can jump back to a chosen reload index and repeat the tail of the list. It does this a set number of times, or forever. The walker does not read memory, execute the records or write responses. It only produces the address sequence, followed by a one-cycle done pulse or a one-cycle error pulse.

Top module: `trl_walker`

## Requirements
- R1: Bits 31:30 of header word 0 carry the descriptor kind, and only the value 3 (transfer-request list) is accepted. Any other kind (0, 1 or 2) makes `err_o` high for exactly one cycle, the cycle after the start pulse is sampled. In that case `rec_valid_o` stays low.
- R2: Header word 0 holds three fields. Bits 13:0 are the last record index (record count minus one), bits 19:14 are the reload index and bits 28:20 are the reload count. Bits 26:24 of header word 1 give the record size: code 0 is 16 bytes, 1 is 32, 2 is 64 and 3 is 128.
- R3: Record i is presented at address base + size*(i+1). The first size-wide slot holds the packet header.
- R4: The response slot for record i is at base + size*(last+2) + 4*i, directly after the whole record area.
- R5: An accepted start makes `rec_valid_o` high in the next cycle with index 0. Each handshake (valid and ready both high at a clock edge) advances the first pass through the indices 0 to last in order. The index never exceeds last.
- R6: After the handshake on index last, one of two things happens. If reloads remain, the next index is the reload index and one reload is used up. If none remain, `rec_valid_o` drops and `done_o` is high for exactly the next cycle. A run therefore issues (last+1) + count*(last-reload+1) records.
- R7: A reload count of 0x1FF repeats the reload loop without end, and `done_o` is never raised.
- R8: The start is refused with the same one-cycle error as R1, and nothing is issued, in two cases: the reload index is greater than last, or the size code is 4 to 7.
- R9: While `rec_valid_o` is high and `rec_ready_i` is low, the record address, response address and index hold their values and valid stays high.
- R10: A start pulse while records are being issued is ignored. It causes no error and does not change the current sequence.
- R11: Reset (rst_n low) returns the walker to idle with `rec_valid_o`, `done_o` and `err_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, sampled only while idle |
| base_i | input | ADDR_W | Descriptor base address |
| hdr0_i | input | 32 | Header word 0 (kind, reload count, reload index, last index) |
| hdr1_i | input | 32 | Header word 1 (record size code) |
| rec_valid_o | output | 1 | A record address is offered |
| rec_ready_i | input | 1 | Consumer takes the offered record |
| rec_addr_o | output | ADDR_W | Address of the offered record |
| rsp_addr_o | output | ADDR_W | Address of its response slot |
| rec_idx_o | output | 14 | Index of the offered record |
| done_o | output | 1 | One-cycle pulse after the final record |
| err_o | output | 1 | One-cycle pulse when a start is refused |

## Verification
The main walk is swept over every combination of last index 0 to 3, every legal reload index, reload counts 0 to 2 and all four size codes. A rotating stall pattern on ready runs throughout the sweep. Cases with the reload index equal to last separate a one-record loop from a loop of several records, and the reload count of 0 separates plain completion from reload. The size codes separate the record stride from the response stride. Directed runs cover the refused starts (each non-list kind, a reload index past last, oversized codes) and an endless loop with a start pulse arriving mid-walk. Together they show that refusals and ignored starts leave the outputs untouched.

// File: rtl/trl_pkg.sv
package trl_pkg;
  localparam int LAST_W = 14;
  localparam int RIDX_W = 6;
  localparam int RCNT_W = 9;
  localparam int SZC_W  = 3;

  localparam logic [1:0]        KIND_TRLIST  = 2'd3;
  localparam logic [RCNT_W-1:0] RCNT_FOREVER = '1;

  typedef struct packed {
    logic [LAST_W-1:0] last;
    logic [RIDX_W-1:0] ridx;
    logic [1:0]        szc;
  } walk_cfg_t;

  typedef enum logic {ST_IDLE, ST_RUN} walk_state_e;
endpackage

// File: rtl/trl_hdr_decode.sv
module trl_hdr_decode
  import trl_pkg::*;
(
  input  logic [31:0]       hdr0_i,
  input  logic [31:0]       hdr1_i,
  output walk_cfg_t         cfg_o,
  output logic [RCNT_W-1:0] rcnt_o,
  output logic              ok_o
);
  localparam int LAST_LSB = 0;
  localparam int RIDX_LSB = LAST_LSB + LAST_W;
  localparam int RCNT_LSB = RIDX_LSB + RIDX_W;
  localparam int KIND_LSB = 30;
  localparam int SZC_LSB  = 24;

  logic [1:0]       kind;
  logic [SZC_W-1:0] szc_full;
  logic             unused_bits;

  assign kind     = hdr0_i[KIND_LSB +: 2];
  assign szc_full = hdr1_i[SZC_LSB +: SZC_W];

  assign cfg_o.last = hdr0_i[LAST_LSB +: LAST_W];
  assign cfg_o.ridx = hdr0_i[RIDX_LSB +: RIDX_W];
  assign cfg_o.szc  = szc_full[1:0];
  assign rcnt_o     = hdr0_i[RCNT_LSB +: RCNT_W];

  // kind must be a list, reload target inside the list, size code 0..3
  assign ok_o = (kind == KIND_TRLIST)
             && (LAST_W'(cfg_o.ridx) <= cfg_o.last)
             && (szc_full[SZC_W-1] == 1'b0);

  assign unused_bits = ^{hdr0_i[29], hdr1_i[31:SZC_LSB+SZC_W], hdr1_i[SZC_LSB-1:0]};
endmodule

// File: rtl/trl_addr_gen.sv
module trl_addr_gen
  import trl_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [1:0]        szc_i,
  input  logic [LAST_W-1:0] last_i,
  input  logic [LAST_W-1:0] idx_i,
  output logic [ADDR_W-1:0] rec_addr_o,
  output logic [ADDR_W-1:0] rsp_addr_o
);
  localparam int MIN_SHIFT = 4;   // 16-byte smallest record
  localparam int RSP_SHIFT = 2;   // 4-byte response slot

  logic [2:0]        shamt;
  logic [ADDR_W-1:0] rec_slot;
  logic [ADDR_W-1:0] rsp_area;

  assign shamt    = 3'(MIN_SHIFT) + {1'b0, szc_i};
  assign rec_slot = ADDR_W'(idx_i) + ADDR_W'(1);
  assign rsp_area = ADDR_W'(last_i) + ADDR_W'(2);

  assign rec_addr_o = base_i + (rec_slot << shamt);
  assign rsp_addr_o = base_i + (rsp_area << shamt) + (ADDR_W'(idx_i) << RSP_SHIFT);
endmodule

// File: rtl/trl_seq.sv
module trl_seq
  import trl_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              cfg_ok_i,
  input  logic [ADDR_W-1:0] base_i,
  input  walk_cfg_t         cfg_i,
  input  logic [RCNT_W-1:0] rcnt_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [LAST_W-1:0] idx_o,
  output walk_cfg_t         cfg_o,
  output logic [ADDR_W-1:0] base_o,
  output logic              done_o,
  output logic              err_o
);
  walk_state_e       state_q, state_d;
  logic [LAST_W-1:0] idx_q, idx_d;
  logic [RCNT_W-1:0] rem_q, rem_d;
  walk_cfg_t         cfg_q;
  logic [ADDR_W-1:0] base_q;
  logic              done_q, done_d, err_q, err_d;
  logic              idx_en, rem_en, cfg_ld, at_last;

  assign at_last = (idx_q == cfg_q.last);
  assign cfg_ld  = (state_q == ST_IDLE) && start_i && cfg_ok_i;

  always_comb begin
    state_d = state_q;
    idx_en  = 1'b0;
    idx_d   = idx_q;
    rem_en  = 1'b0;
    rem_d   = rem_q;
    done_d  = 1'b0;
    err_d   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          if (cfg_ok_i) begin
            state_d = ST_RUN;
            idx_en  = 1'b1;
            idx_d   = '0;
            rem_en  = 1'b1;
            rem_d   = rcnt_i;
          end else begin
            err_d = 1'b1;
          end
        end
      end
      ST_RUN: begin
        if (ready_i) begin
          if (!at_last) begin
            idx_en = 1'b1;
            idx_d  = idx_q + LAST_W'(1);
          end else if (rem_q == '0) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end else begin
            idx_en = 1'b1;
            idx_d  = LAST_W'(cfg_q.ridx);
            if (rem_q != RCNT_FOREVER) begin
              rem_en = 1'b1;
              rem_d  = rem_q - RCNT_W'(1);
            end
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_en) idx_q <= idx_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rem_q <= '0;
    else if (rem_en) rem_q <= rem_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      base_q <= '0;
    end else if (cfg_ld) begin
      cfg_q  <= cfg_i;
      base_q <= base_i;
    end
  end

  assign valid_o = (state_q == ST_RUN);
  assign idx_o   = idx_q;
  assign cfg_o   = cfg_q;
  assign base_o  = base_q;
  assign done_o  = done_q;
  assign err_o   = err_q;

  p_err_after_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (!valid_o && $past(start_i)));

  p_idx_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (idx_o <= cfg_q.last));

  p_done_after_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!valid_o && $past(valid_o && ready_i)));

  p_forever_no_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($past(rem_q) != RCNT_FOREVER));

  p_busy_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && start_i && !ready_i) |=> (valid_o && !err_o && $stable(idx_o)));
endmodule

// File: rtl/trl_walker.sv
module trl_walker
  import trl_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [31:0]       hdr0_i,
  input  logic [31:0]       hdr1_i,
  output logic              rec_valid_o,
  input  logic              rec_ready_i,
  output logic [ADDR_W-1:0] rec_addr_o,
  output logic [ADDR_W-1:0] rsp_addr_o,
  output logic [LAST_W-1:0] rec_idx_o,
  output logic              done_o,
  output logic              err_o
);
  walk_cfg_t         dec_cfg, run_cfg;
  logic [RCNT_W-1:0] dec_rcnt;
  logic              dec_ok;
  logic [ADDR_W-1:0] run_base;

  trl_hdr_decode u_dec (
    .hdr0_i (hdr0_i),
    .hdr1_i (hdr1_i),
    .cfg_o  (dec_cfg),
    .rcnt_o (dec_rcnt),
    .ok_o   (dec_ok)
  );

  trl_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .cfg_ok_i (dec_ok),
    .base_i   (base_i),
    .cfg_i    (dec_cfg),
    .rcnt_i   (dec_rcnt),
    .ready_i  (rec_ready_i),
    .valid_o  (rec_valid_o),
    .idx_o    (rec_idx_o),
    .cfg_o    (run_cfg),
    .base_o   (run_base),
    .done_o   (done_o),
    .err_o    (err_o)
  );

  trl_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
    .base_i     (run_base),
    .szc_i      (run_cfg.szc),
    .last_i     (run_cfg.last),
    .idx_i      (rec_idx_o),
    .rec_addr_o (rec_addr_o),
    .rsp_addr_o (rsp_addr_o)
  );

  p_hold_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid_o && !rec_ready_i) |=> (rec_valid_o && $stable(rec_addr_o)
      && $stable(rsp_addr_o) && $stable(rec_idx_o)));

  p_step_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rec_valid_o) |-> (rec_idx_o == '0));

  p_pulse_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && err_o));
endmodule

// File: tb/trl_walker_bench.sv
module trl_walker_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [31:0] base_i, hdr0_i, hdr1_i;
  logic        rec_ready_i;
  logic        rec_valid_o, done_o, err_o;
  logic [31:0] rec_addr_o, rsp_addr_o;
  logic [13:0] rec_idx_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trl_walker u_trl_walker (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_i(base_i),
    .hdr0_i(hdr0_i), .hdr1_i(hdr1_i), .rec_valid_o(rec_valid_o),
    .rec_ready_i(rec_ready_i), .rec_addr_o(rec_addr_o), .rsp_addr_o(rsp_addr_o),
    .rec_idx_o(rec_idx_o), .done_o(done_o), .err_o(err_o)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk0(int kind, int last, int ridx, int rcnt);
    return {2'(kind), 1'b0, 9'(rcnt), 6'(ridx), 14'(last)};
  endfunction

  function automatic logic [31:0] mk1(int szc);
    return {5'b0, 3'(szc), 24'b0};
  endfunction

  task automatic pulse_start(input logic [31:0] b, input logic [31:0] h0, input logic [31:0] h1);
    @(negedge clk);
    base_i = b; hdr0_i = h0; hdr1_i = h1; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic run_cfg(input logic [31:0] b, input int l, input int r, input int c, input int s);
    int e = 0, rem = c, n = 0, cyc = 0;
    bit fin = 0, want_done = 0, prev_stall = 0;
    logic [31:0] sz = 32'd16 << s;
    logic [31:0] ha = '0, hr = '0;
    logic [13:0] hi = '0;
    pulse_start(b, mk0(3, l, r, c), mk1(s));
    while (!fin && cyc < 400) begin
      if (prev_stall && rec_valid_o)
        chk(rec_addr_o == ha && rsp_addr_o == hr && rec_idx_o == hi, "R9 hold under stall",
            {rec_addr_o, 18'b0, rec_idx_o}, {ha, 18'b0, hi});
      prev_stall = 0;
      if (err_o) chk(0, "R8 unexpected error on legal header", 1, 0);
      if (done_o) begin
        chk(want_done, "R6 done timing", 1, 64'(want_done));
        fin = 1;
      end else if (rec_valid_o) begin
        if (want_done) chk(0, "R6 record after final", 64'(rec_idx_o), 0);
        rec_ready_i = (((cyc * 7) + l + s) % 4) != 3;
        if (!rec_ready_i) begin
          prev_stall = 1; ha = rec_addr_o; hr = rsp_addr_o; hi = rec_idx_o;
        end else begin
          chk(rec_idx_o == 14'(e), "R5 R6 record index", 64'(rec_idx_o), 64'(e));
          chk(rec_addr_o == b + 32'(e + 1) * sz, "R3 record address (R2 size)",
              64'(rec_addr_o), 64'(b + 32'(e + 1) * sz));
          chk(rsp_addr_o == b + 32'(l + 2) * sz + 32'(4 * e), "R4 response address",
              64'(rsp_addr_o), 64'(b + 32'(l + 2) * sz + 32'(4 * e)));
          n++;
          if (e < l) e++;
          else if (rem == 0) want_done = 1;
          else begin e = r; rem--; end
        end
      end
      @(negedge clk);
      cyc++;
    end
    rec_ready_i = 1'b0;
    chk(fin, "R6 run finished", 64'(fin), 1);
    chk(n == (l + 1) + c * (l - r + 1), "R6 record count", 64'(n), 64'((l + 1) + c * (l - r + 1)));
  endtask

  task automatic bad_start(input logic [31:0] h0, input logic [31:0] h1, input string req);
    pulse_start(32'h4000_0000, h0, h1);
    chk(err_o == 1'b1, req, 64'(err_o), 1);
    chk(rec_valid_o == 1'b0, req, 64'(rec_valid_o), 0);
    @(negedge clk);
    chk(err_o == 1'b0, req, 64'(err_o), 0);
    chk(rec_valid_o == 1'b0, req, 64'(rec_valid_o), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; rec_ready_i = 1'b0;
    base_i = '0; hdr0_i = '0; hdr1_i = '0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(!rec_valid_o && !done_o && !err_o, "R11 reset outputs low",
        {rec_valid_o, done_o, err_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!rec_valid_o && !done_o && !err_o, "R11 idle after release",
        {rec_valid_o, done_o, err_o}, 0);

    // R1 wrong kinds
    for (int k = 0; k < 3; k++) bad_start(mk0(k, 2, 0, 1), mk1(0), "R1 non-list kind refused");
    // R8 bad reload index and size codes
    bad_start(mk0(3, 2, 3, 1), mk1(1), "R8 reload index past last");
    bad_start(mk0(3, 0, 63, 0), mk1(0), "R8 reload index past last");
    bad_start(mk0(3, 2, 0, 1), mk1(4), "R8 size code 4");
    bad_start(mk0(3, 2, 0, 1), mk1(7), "R8 size code 7");

    // main sweep
    for (int l = 0; l < 4; l++)
      for (int r = 0; r <= l; r++)
        for (int c = 0; c < 3; c++)
          for (int s = 0; s < 4; s++)
            run_cfg(32'h8000_0000 + 32'((l * 48 + r * 12 + c * 4 + s) << 12), l, r, c, s);

    // R7 endless loop with R10 busy start
    begin
      int e = 0;
      bit saw_done = 0;
      pulse_start(32'h0010_0000, mk0(3, 2, 1, 511), mk1(1));
      rec_ready_i = 1'b1;
      for (int t = 0; t < 40; t++) begin
        if (t == 10) begin
          start_i = 1'b1; hdr0_i = mk0(1, 5, 0, 0);
        end
        if (t == 11) begin
          start_i = 1'b0;
          chk(err_o == 1'b0, "R10 busy start gives no error", 64'(err_o), 0);
        end
        if (done_o) saw_done = 1;
        chk(rec_valid_o && rec_idx_o == 14'(e), "R7 R10 endless index sequence",
            64'(rec_idx_o), 64'(e));
        e = (e == 2) ? 1 : e + 1;
        @(negedge clk);
      end
      chk(!saw_done, "R7 no done in endless loop", 64'(saw_done), 0);
      rec_ready_i = 1'b0;
      rst_n = 1'b0;
      @(negedge clk);
      chk(!rec_valid_o && !done_o && !err_o, "R11 reset stops walk",
          {rec_valid_o, done_o, err_o}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(!rec_valid_o, "R11 stays idle after reset", 64'(rec_valid_o), 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule